// File: doc/BRIEF.md
# Split-Capacitor Discharge Steering

This block balances a stacked output capacitor pair whose tap is meant to sit at one third of the bus voltage. A downstream converter controller produces one PWM gate signal. The block passes each of its pulses, whole, to one of two primary switches. The top-side switch draws charge from the upper capacitor. The bottom-side switch draws charge from the lower capacitor. Which switch gets a pulse is chosen per switching cycle, so the balance is set by counting pulses and never by trimming duty.

Two comparator flags report where the tap voltage sits. The over flag means the tap is above its band, so the lower capacitor must discharge. The under flag means the tap is below its band, so the upper capacitor must discharge. With neither flag set, or with both set, pulses alternate between the two sides. The PWM input and both flags pass through the same synchronizer chain, so a flag and a PWM edge that arrive together are also seen together. The side is fixed when the synchronized PWM rises. It is held until the PWM falls.

Top module: `tap_split_steer`

## Requirements
- R1: Each PWM pulse appears on exactly one of `top_gate_o` and `bot_gate_o`, at its full width. The other output stays low for that pulse. The two outputs are never high in the same cycle.
- R2: With both flags low, consecutive pulses alternate between the two sides.
- R3: With only `over_i` high when a pulse starts, that pulse goes to `bot_gate_o`.
- R4: With only `under_i` high when a pulse starts, that pulse goes to `top_gate_o`.
- R5: With both flags high when a pulse starts, the block alternates as in R2.
- R6: The side is decided from the flag values seen at the synchronized rising edge of `pwm_i`. A flag change while the pulse is high has no effect on that pulse.
- R7: `pwm_i`, `over_i` and `under_i` each pass through SYNC_STAGES flops (default 2). An output rises SYNC_STAGES+1 clock edges after `pwm_i` rises. A flag that changes in the same cycle as the PWM rising edge governs that pulse.
- R8: While `rst_ni` is low, and afterwards until a pulse arrives, both outputs are low. The first pulse after reset goes to `bot_gate_o` when no single flag forces the side.
- R9: Alternation resumes from the side of the last pulse actually routed. After a run of forced pulses, the next free pulse goes to the opposite side of the last forced one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 1 | Downstream converter PWM gate |
| over_i | input | 1 | Tap above band: favour bottom discharge |
| under_i | input | 1 | Tap below band: favour top discharge |
| top_gate_o | output | 1 | Gate of the switch discharging the upper capacitor |
| bot_gate_o | output | 1 | Gate of the switch discharging the lower capacitor |

## Verification
The side decision and a flag update can fall in the same cycle. There are two ways this is provoked. In the first, the bench moves the flags on the very negative edge on which it raises `pwm_i`; the pulse must then follow the new flags. In the second, the bench flips the flags halfway through a pulse; the pulse must stay on the side chosen at its start. Each pulse is judged by counting the high cycles on each output over a window. The counts are compared with the width and side predicted by a bench model of the alternation state. The cycle of the first high sample is checked against the synchronizer latency.

// File: rtl/tap_steer_pkg.sv
package tap_steer_pkg;
  typedef enum logic {
    SIDE_BOT = 1'b0,
    SIDE_TOP = 1'b1
  } side_e;

  localparam int unsigned SIG_PWM   = 0;
  localparam int unsigned SIG_OVER  = 1;
  localparam int unsigned SIG_UNDER = 2;
  localparam int unsigned SIG_W     = 3;
endpackage

// File: rtl/tap_steer_sync.sv
module tap_steer_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[s] <= '0;
        else         stg[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[s] <= '0;
        else         stg[s] <= stg[s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/tap_steer_pick.sv
module tap_steer_pick
  import tap_steer_pkg::*;
(
  input  side_e last_i,
  input  logic  over_i,
  input  logic  under_i,
  output side_e side_o
);
  always_comb begin
    unique case ({over_i, under_i})
      2'b10:   side_o = SIDE_BOT;
      2'b01:   side_o = SIDE_TOP;
      default: side_o = (last_i == SIDE_TOP) ? SIDE_BOT : SIDE_TOP;
    endcase
  end
endmodule

// File: rtl/tap_steer_route.sv
module tap_steer_route
  import tap_steer_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  pwm_i,
  input  side_e pick_i,
  output side_e last_o,
  output logic  rise_o,
  output logic  top_o,
  output logic  bot_o
);
  logic  pwm_d;
  side_e held_q;
  side_e sel_now;
  logic  top_q, bot_q;

  assign rise_o  = pwm_i & ~pwm_d;
  assign sel_now = rise_o ? pick_i : held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwm_d  <= 1'b0;
      held_q <= SIDE_TOP;  // first free pulse lands on bottom
      top_q  <= 1'b0;
      bot_q  <= 1'b0;
    end else begin
      pwm_d <= pwm_i;
      if (rise_o) held_q <= pick_i;
      top_q <= pwm_i & (sel_now == SIDE_TOP);
      bot_q <= pwm_i & (sel_now == SIDE_BOT);
    end
  end

  assign last_o = held_q;
  assign top_o  = top_q;
  assign bot_o  = bot_q;

  AST_GATES_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(top_q && bot_q)); // R1
  AST_NO_SPLIT_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (top_q && pwm_i && pwm_d) |=> top_q); // R6
  AST_NO_SPLIT_BOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bot_q && pwm_i && pwm_d) |=> bot_q); // R6
endmodule

// File: rtl/tap_split_steer.sv
module tap_split_steer
  import tap_steer_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  input  logic over_i,
  input  logic under_i,
  output logic top_gate_o,
  output logic bot_gate_o
);
  logic [SIG_W-1:0] raw, syn;
  side_e pick, last_side;
  logic  rise;

  always_comb begin
    raw            = '0;
    raw[SIG_PWM]   = pwm_i;
    raw[SIG_OVER]  = over_i;
    raw[SIG_UNDER] = under_i;
  end

  tap_steer_sync #(.WIDTH(SIG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  tap_steer_pick u_pick (
    .last_i (last_side),
    .over_i (syn[SIG_OVER]),
    .under_i(syn[SIG_UNDER]),
    .side_o (pick)
  );

  tap_steer_route u_route (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pwm_i (syn[SIG_PWM]),
    .pick_i(pick),
    .last_o(last_side),
    .rise_o(rise),
    .top_o (top_gate_o),
    .bot_o (bot_gate_o)
  );

  AST_OVER_TO_BOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && syn[SIG_OVER] && !syn[SIG_UNDER]) |=> bot_gate_o); // R3
  AST_UNDER_TO_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && syn[SIG_UNDER] && !syn[SIG_OVER]) |=> top_gate_o); // R4
  AST_FREE_ALTERNATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && (syn[SIG_OVER] == syn[SIG_UNDER]))
      |=> (top_gate_o == ($past(last_side) == SIDE_BOT))); // R2
  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !syn[SIG_PWM] |=> !(top_gate_o || bot_gate_o)); // R8
endmodule

// File: tb/sim_tap_split_steer.sv
module sim_tap_split_steer;
  localparam int CLK_PERIOD = 10;
  localparam int STAGES     = 2;
  localparam int LAT        = STAGES + 1;

  logic clk = 1'b0, rst_ni = 1'b0, pwm = 1'b0, ov = 1'b0, un = 1'b0;
  logic top_g, bot_g;
  int   n_chk = 0, n_bad = 0;
  bit   last_top = 1'b1;  // model: last routed side was top

  always #(CLK_PERIOD/2) clk = ~clk;

  tap_split_steer #(.SYNC_STAGES(STAGES)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .pwm_i(pwm), .over_i(ov), .under_i(un),
    .top_gate_o(top_g), .bot_gate_o(bot_g)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input bit o, input bit u, input int w, input int g,
                       input bit flip_mid, input string req_in);
    int n_top = 0, n_bot = 0, n_both = 0, first = -1;
    bit exp_top;
    string req;
    if (o && !u)      exp_top = 1'b0;
    else if (u && !o) exp_top = 1'b1;
    else              exp_top = !last_top;
    last_top = exp_top;
    if (req_in != "")   req = req_in;
    else if (o && !u)   req = "R3";
    else if (u && !o)   req = "R4";
    else if (o && u)    req = "R5";
    else                req = "R2";
    @(negedge clk);
    pwm = 1'b1; ov = o; un = u;   // flags move with the PWM edge (R7)
    for (int j = 1; j <= w + g; j++) begin
      @(negedge clk);
      if (top_g) n_top++;
      if (bot_g) n_bot++;
      if (top_g && bot_g) n_both++;
      if ((top_g || bot_g) && first < 0) first = j;
      if (j == w) pwm = 1'b0;
      if (flip_mid && j == (w + 1) / 2 && j < w) begin ov = !o; un = !u; end
    end
    chk(n_top == (exp_top ? w : 0), req, n_top, exp_top ? w : 0);
    chk(n_bot == (exp_top ? 0 : w), req, n_bot, exp_top ? 0 : w);
    chk(n_both == 0, "R1", n_both, 0);
    chk(first == LAT, "R7", first, LAT);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!top_g && !bot_g, "R8", {top_g, bot_g}, 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    chk(!top_g && !bot_g, "R8", {top_g, bot_g}, 0);
    pulse(1'b0, 1'b0, 3, 5, 1'b0, "R8");        // first free pulse -> bottom
    for (int k = 0; k < 4; k++) pulse(1'b0, 1'b0, 2, 4, 1'b0, "");
    for (int rep = 0; rep < 2; rep++)
      for (int c = 0; c < 4; c++)
        for (int w = 1; w <= 4; w++) pulse(c[1], c[0], w, 4 + w, 1'b0, "");
    for (int c = 0; c < 4; c++) pulse(c[1], c[0], 6, 5, 1'b1, "R6");
    pulse(1'b1, 1'b0, 2, 4, 1'b0, "R9");
    pulse(1'b1, 1'b0, 2, 4, 1'b0, "R9");
    pulse(1'b0, 1'b0, 2, 4, 1'b0, "R9");        // resumes on top
    pulse(1'b0, 1'b1, 2, 4, 1'b0, "R9");
    pulse(1'b1, 1'b1, 2, 4, 1'b0, "R9");        // after top -> bottom
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule